// File: doc/BRIEF.md
# Timer/Event Counter with Single-Shot Pulse Capture

This block is a programmable up-counter that a processor configures through a small write port. It has three counting modes. In timer mode it counts a clock divided by a power of two. In event mode it counts the chosen edge of an external input. In pulse mode it measures how long one pulse on that input lasts, in prescaled clock units. The counter starts from a software-loaded preload value. When it passes its all-ones value it reloads the preload value, sets a sticky pending flag and toggles a divided-frequency output.

Pulse mode takes single-shot measurements. Software arms the block by setting the run bit. The block then waits for the leading transition and counts until the trailing transition, at which point hardware clears the run bit. The count is left holding the pulse length. Further activity on the input changes nothing until software arms the block again. The external input passes through a two-stage synchronizer before edge detection. A polarity bit selects the active edge or the active pulse level.

Top module: `evt_timer`

## Requirements
- R1: After reset the count, preload, run bit, pending flag, interrupt request and divided-frequency output are all zero.
- R2: In timer mode (mode field 00, control bits [1:0]) with prescale select n (control bits [4:2]), the count increments once every 2^n clocks. The first increment lands 2^n clocks after the write that set the run bit (control bit 7).
- R3: An increment from the all-ones count loads the preload value into the counter and sets the pending flag on the same clock edge.
- R4: The pending flag stays set until a write to address 2 with bit 1 set. irq_o is the pending flag ANDed with the interrupt enable (control bit 6). Masking hides the request but does not lose it.
- R5: An internal divider bit toggles on every overflow. fdiv_o shows that bit while the divider-on bit (address 2, bit 0) is 1, and is low while it is 0.
- R6: In event mode (mode 01) each active edge of ext_i (rising when the polarity bit, control bit 5, is 0; falling when it is 1) increments the count. The change appears three clocks after the input changes.
- R7: In pulse mode (mode 10), after the run bit is set, counting waits for a leading transition into the active level (high when polarity is 0, low when it is 1). It then counts the prescaled clock until the trailing transition. A pulse L clocks long that starts from preload 0 leaves a count of floor(L/2^n).
- R8: In pulse mode the trailing transition clears the run bit in hardware. Later transitions on ext_i do not change the count until software sets the run bit again.
- R9: In timer and event modes only a software write clears the run bit. While the run bit is 0 the count holds.
- R10: A write to the preload register (address 0) while the run bit is 0 also loads the count. While the run bit is 1 it changes only the reload value used at the next overflow.
- R11: Mode 11 holds the count even with the run bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 preload, 1 control, 2 auxiliary |
| wr_data_i | input | 8 | Write data |
| ext_i | input | 1 | External event / pulse input, asynchronous |
| count_o | output | 8 | Current count |
| run_o | output | 1 | Current run bit |
| irq_o | output | 1 | Overflow interrupt request |
| fdiv_o | output | 1 | Gated divided-frequency output |

## Verification
A stale prescaler phase shows up as a wrong overflow time of up to 2^n clocks. The bench therefore times the interrupt for every prescale value, which exposes it within one overflow period. A wrong pulse-state register either misses the leading edge or keeps counting after the trailing edge. The count and run_o then disagree with floor(L/2^n) within a few clocks of the pulse end. A wrong reload, a lost pending flag or a missing divider toggle each appear at the ports on the first overflow that follows.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_PULSE = 2'b10,
        MODE_HOLD  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        PW_IDLE  = 2'b00,
        PW_ARMED = 2'b01,
        PW_MEAS  = 2'b10
    } pw_state_e;

    localparam logic [1:0] ADDR_PRELOAD = 2'd0;
    localparam logic [1:0] ADDR_CTRL    = 2'd1;
    localparam logic [1:0] ADDR_AUX     = 2'd2;

    localparam int AUX_FDIV_ON_BIT  = 0;
    localparam int AUX_PEND_CLR_BIT = 1;

endpackage

// File: rtl/evt_input_sync.sv
module evt_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = ~({DIV_W{1'b1}} << sel_i);
        tick_o = en_i && ((div_q & mask) == mask);
        div_d  = en_i ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && sel_i != '0) |=> (!tick_o || sel_i == '0)); // R2

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] preload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             fdiv_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             fdiv;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d   = c_q;
        ovf_o = 1'b0;
        if (load_i) begin
            c_d.count = load_val_i;
        end else if (inc_i) begin
            if (c_q.count == CNT_MAX) begin
                c_d.count = preload_i;
                c_d.fdiv  = ~c_q.fdiv;
                ovf_o     = 1'b1;
            end else begin
                c_d.count = c_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o = c_q.count;
    assign fdiv_o  = c_q.fdiv;

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (c_q.count == $past(preload_i))); // R3
    AST_FDIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (c_q.fdiv != $past(c_q.fdiv))); // R5

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_SEL_W   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             ext_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             irq_o,
    output logic             fdiv_o
);
    // control register field positions
    localparam int CTL_PSC_LSB = 2;
    localparam int CTL_POL_BIT = CTL_PSC_LSB + PSC_SEL_W;
    localparam int CTL_IE_BIT  = CTL_POL_BIT + 1;
    localparam int CTL_RUN_BIT = CTL_IE_BIT + 1;

    typedef struct packed {
        logic [CNT_W-1:0]     preload;
        tmode_e               mode;
        logic [PSC_SEL_W-1:0] psc;
        logic                 pol;
        logic                 ie;
        logic                 run;
        logic                 fdiv_on;
        logic                 pend;
        pw_state_e            pw;
    } regs_t;

    regs_t r_d, r_q;

    logic             rise, fall, lead, trail;
    logic             tick, psc_en, inc, ld, ovf, fdiv_raw;
    logic             wr_pre, wr_ctl, wr_aux, pend_clr;
    logic [CNT_W-1:0] count_w;

    evt_input_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (ext_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    evt_prescaler #(.SEL_W(PSC_SEL_W)) i_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (psc_en),
        .sel_i  (r_q.psc),
        .tick_o (tick)
    );

    evt_count_core #(.CNT_W(CNT_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ld),
        .load_val_i (wr_data_i),
        .inc_i      (inc),
        .preload_i  (r_q.preload),
        .count_o    (count_w),
        .ovf_o      (ovf),
        .fdiv_o     (fdiv_raw)
    );

    // strobes and edge selection
    always_comb begin
        wr_pre   = wr_en_i && (wr_addr_i == ADDR_PRELOAD);
        wr_ctl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_aux   = wr_en_i && (wr_addr_i == ADDR_AUX);
        pend_clr = wr_aux && wr_data_i[AUX_PEND_CLR_BIT];
        lead     = r_q.pol ? fall : rise;
        trail    = r_q.pol ? rise : fall;
        ld       = wr_pre && !r_q.run;
    end

    // increment source per mode
    always_comb begin
        psc_en = 1'b0;
        inc    = 1'b0;
        unique case (r_q.mode)
            MODE_TIMER: begin
                psc_en = r_q.run;
                inc    = r_q.run && tick;
            end
            MODE_EVENT: begin
                inc    = r_q.run && lead;
            end
            MODE_PULSE: begin
                psc_en = r_q.run && (r_q.pw == PW_MEAS);
                inc    = r_q.run && (r_q.pw == PW_MEAS) && tick;
            end
            default: begin
                psc_en = 1'b0;
                inc    = 1'b0;
            end
        endcase
    end

    // next-state of all registers
    always_comb begin
        r_d = r_q;

        // single-shot pulse capture sequencing
        if (!r_q.run || r_q.mode != MODE_PULSE) begin
            r_d.pw = PW_IDLE;
        end else begin
            unique case (r_q.pw)
                PW_IDLE:  r_d.pw = PW_ARMED;
                PW_ARMED: if (lead) r_d.pw = PW_MEAS;
                PW_MEAS: begin
                    if (trail) begin
                        r_d.pw  = PW_IDLE;
                        r_d.run = 1'b0;
                    end
                end
                default:  r_d.pw = PW_IDLE;
            endcase
        end

        // sticky pending flag: overflow wins over a same-cycle clear
        if (pend_clr) r_d.pend = 1'b0;
        if (ovf)      r_d.pend = 1'b1;

        // software writes (control write overrides the hardware clear)
        if (wr_pre) r_d.preload = wr_data_i;
        if (wr_ctl) begin
            r_d.mode = tmode_e'(wr_data_i[1:0]);
            r_d.psc  = wr_data_i[CTL_PSC_LSB +: PSC_SEL_W];
            r_d.pol  = wr_data_i[CTL_POL_BIT];
            r_d.ie   = wr_data_i[CTL_IE_BIT];
            r_d.run  = wr_data_i[CTL_RUN_BIT];
        end
        if (wr_aux) r_d.fdiv_on = wr_data_i[AUX_FDIV_ON_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{preload: '0, mode: MODE_TIMER, psc: '0, pol: 1'b0, ie: 1'b0,
                     run: 1'b0, fdiv_on: 1'b0, pend: 1'b0, pw: PW_IDLE};
        end else begin
            r_q <= r_d;
        end
    end

    assign count_o = count_w;
    assign run_o   = r_q.run;
    assign irq_o   = r_q.pend && r_q.ie;
    assign fdiv_o  = fdiv_raw && r_q.fdiv_on;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend && !pend_clr) |=> r_q.pend); // R4
    AST_HW_CLEAR_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.run && !wr_ctl) |=> (r_q.run || $past(r_q.mode) == MODE_PULSE)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.run && !wr_pre) |=> $stable(count_w)); // R9
    AST_HOLD_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == MODE_HOLD && !wr_pre) |=> $stable(count_w)); // R11

endmodule

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       ext_i = 1'b0;
    logic [7:0] count_o;
    logic       run_o, irq_o, fdiv_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_timer i_evt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ext_i(ext_i), .count_o(count_o), .run_o(run_o),
        .irq_o(irq_o), .fdiv_o(fdiv_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge; returns at the following negedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [7:0] ctl(input int mode, input int n, input int pol,
                                       input int ie, input int run);
        return 8'((run << 7) | (ie << 6) | (pol << 5) | (n << 2) | mode);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic pulse_case(input int pol, input int n, input int len);
        logic idle;
        idle = (pol != 0);
        wr(2'd1, ctl(2, n, pol, 0, 0));
        ext_i = idle;
        wait_cyc(4);
        wr(2'd0, 8'd0);
        wr(2'd1, ctl(2, n, pol, 0, 1));
        wait_cyc(3);
        ext_i = ~idle;
        wait_cyc(len);
        ext_i = idle;
        wait_cyc(6);
        chk($sformatf("R7 pulse pol=%0d n=%0d L=%0d", pol, n, len), count_o, len >> n);
        chk("R8 run cleared after pulse", run_o, 0);
        // a second pulse must be ignored
        ext_i = ~idle;
        wait_cyc(5);
        ext_i = idle;
        wait_cyc(6);
        chk("R8 later pulse ignored", count_o, len >> n);
        chk("R8 run stays clear", run_o, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int k;
        int c;
        do_reset();

        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 run", run_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 fdiv", fdiv_o, 0);
        wr(2'd1, ctl(0, 0, 0, 0, 1));   // preload is 0 after reset: count starts from 0
        wait_cyc(3);
        chk("R1 preload zero", count_o, 3);
        wr(2'd1, ctl(0, 0, 0, 0, 0));

        // R2 rate sweep
        for (int n = 0; n < 4; n++) begin
            wr(2'd0, 8'd0);
            wr(2'd1, ctl(0, n, 0, 0, 1));
            wait_cyc(20);
            chk($sformatf("R2 count after 20 clk n=%0d", n), count_o, 20 >> n);
            wr(2'd1, ctl(0, n, 0, 0, 0));
            c = count_o;
            wait_cyc(10);
            chk("R9 stopped count holds", count_o, c);
        end

        // R3 overflow timing over every prescale value
        for (int n = 0; n < 8; n++) begin
            wr(2'd1, ctl(0, n, 0, 1, 0));
            wr(2'd2, 8'h02);
            wr(2'd0, 8'd250);
            wr(2'd1, ctl(0, n, 0, 1, 1));
            k = 0;
            while (!irq_o && k < 3000) begin
                @(negedge clk);
                k++;
            end
            chk($sformatf("R3 overflow delay n=%0d", n), k, 6 << n);
            chk("R3 reloaded value", count_o, 250);
            chk("R9 run kept after overflow", run_o, 1);
        end
        wr(2'd1, ctl(0, 0, 0, 0, 0));

        // R10 preload write while running
        wr(2'd0, 8'd253);
        chk("R10 idle write loads count", count_o, 253);
        wr(2'd1, ctl(0, 0, 0, 0, 1));
        wr(2'd0, 8'd10);
        chk("R10 running write leaves count", count_o, 254);
        wait_cyc(2);
        chk("R10 new preload used on wrap", count_o, 10);
        wr(2'd1, ctl(0, 0, 0, 0, 0));

        // R4 masking and sticky pending
        do_reset();
        wr(2'd0, 8'd254);
        wr(2'd1, ctl(0, 0, 0, 0, 1));
        wait_cyc(5);
        chk("R4 masked irq low", irq_o, 0);
        wr(2'd1, ctl(0, 0, 0, 1, 0));
        chk("R4 unmask shows pending", irq_o, 1);
        wait_cyc(5);
        chk("R4 pending sticky", irq_o, 1);
        wr(2'd2, 8'h02);
        chk("R4 cleared by write", irq_o, 0);

        // R5 divided output
        do_reset();
        wr(2'd2, 8'h01);
        wr(2'd0, 8'd254);
        wr(2'd1, ctl(0, 0, 0, 0, 1));
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            chk($sformatf("R5 fdiv after %0d clk", j), fdiv_o, (j / 2) % 2);
        end
        wr(2'd2, 8'h00);
        for (int j = 0; j < 6; j++) begin
            chk("R5 fdiv gated low", fdiv_o, 0);
            @(negedge clk);
        end
        wr(2'd1, ctl(0, 0, 0, 0, 0));

        // R6 event counting, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int nn = 1; nn <= 7; nn += 3) begin
                wr(2'd1, ctl(1, 0, pol, 0, 0));
                ext_i = (pol != 0);
                wait_cyc(4);
                wr(2'd0, 8'd0);
                wr(2'd1, ctl(1, 0, pol, 0, 1));
                ext_i = ~ext_i;
                wait_cyc(2);
                chk("R6 no change after 2 clk", count_o, 0);
                wait_cyc(1);
                chk("R6 edge counted after 3 clk", count_o, 1);
                ext_i = ~ext_i;
                wait_cyc(2);
                for (int e = 1; e < nn; e++) begin
                    ext_i = ~ext_i;
                    wait_cyc(2);
                    ext_i = ~ext_i;
                    wait_cyc(2);
                end
                wait_cyc(4);
                chk($sformatf("R6 edges pol=%0d N=%0d", pol, nn), count_o, nn);
                chk("R9 run kept in event mode", run_o, 1);
            end
        end

        // R7/R8 pulse capture sweep
        for (int n = 0; n < 4; n++) begin
            pulse_case(0, n, 1);
            pulse_case(0, n, 5);
            pulse_case(0, n, 12);
            pulse_case(0, n, 33);
        end
        pulse_case(1, 0, 9);
        pulse_case(1, 2, 17);

        // R11 hold mode
        wr(2'd1, ctl(3, 0, 0, 0, 0));
        wr(2'd0, 8'd7);
        wr(2'd1, ctl(3, 0, 0, 0, 1));
        wait_cyc(10);
        chk("R11 hold mode frozen", count_o, 7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule